// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor that completes every instruction in one clock cycle. It runs nine instructions: load word, store word, the five register-to-register operations (add, subtract, and, or, signed set-on-less-than), branch-if-equal and an absolute jump. Every instruction is fetched, decoded, executed and retired in the cycle it is addressed. The program counter, register writes and memory writes all take effect on the rising edge that ends that cycle.

Instruction memory and data memory are internal word arrays. The surrounding environment loads them before reset is released. The program counter and the data-memory write bus are brought out to the ports, so the effect of each instruction can be seen from outside. A register's value becomes visible when a store instruction puts it on the write bus.

A control decoder turns the opcode, and the function field for register-to-register operations, into a small bundle of strobes. A datapath then uses those strobes to steer its multiplexers: destination select, second-operand select, write-back select, and next-PC select. The next-PC select takes the branch strobe ANDed with the ALU zero flag.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, the PC is held at 0 on every rising edge, and `dmemWe` stays low, so no memory or register write takes effect.
- R2: Any instruction other than a taken branch or a jump sets the next PC to PC + 4. The PC is always word aligned.
- R3: An instruction with opcode 0x00 writes to register rd (bits 15:11) the result of rs (bits 25:21) and rt (bits 20:16), chosen by funct (bits 5:0): 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0).
- R4: A store (opcode 0x2B) drives `dmemWe` high, drives `dmemAddr` with rs + offset, and drives `dmemWdata` with rt, in the cycle it executes. `dmemWe` is high only for stores.
- R5: A load (opcode 0x23) writes the data-memory word at rs + offset into register rt. Data-memory word index is address bits 7:2.
- R6: Register 0 always reads as zero. A write that targets it leaves it zero.
- R7: Branch-if-equal (opcode 0x04) compares rs and rt by subtraction. When they are equal, the next PC is PC + 4 + (offset × 4). Otherwise the next PC is PC + 4.
- R8: A jump (opcode 0x02) sets the next PC to the upper four bits of PC + 4, followed by instruction bits 25:0, followed by two zero bits.
- R9: The 16-bit offset (bits 15:0) is sign extended from bit 15, so negative offsets reach lower addresses and branch backwards.
- R10: Any other opcode writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pcOut | output | 32 | Address of the instruction executing this cycle |
| dmemWe | output | 1 | Data-memory write strobe of the current instruction |
| dmemAddr | output | 32 | ALU result; the data-memory byte address for loads and stores |
| dmemWdata | output | 32 | Register rt value, written on a store |

## Verification
A wrong decode, a wrong ALU result or a lost register write is invisible at the ports until a store puts the affected register on the write bus. The data value is then off from that cycle on. A wrong next-PC choice shows on `pcOut` on the very next edge, and every later fetch diverges from that point. The bench therefore compares `pcOut` and the store bus against an instruction-level model in every cycle. It also stores every register class it exercises, so that any corrupted state shows within a few instructions.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREG   = 1 << REG_AW;
  localparam int IMM_W  = 16;

  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } aluCtl_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aluOp_e;

  typedef struct packed {
    logic    regDst;
    logic    aluSrc;
    logic    memToReg;
    logic    regWrite;
    logic    memRead;
    logic    memWrite;
    logic    branch;
    logic    jump;
    aluCtl_e aluCtl;
  } ctrl_t;

endpackage

// File: rtl/sc_control.sv
module sc_control
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  aluOp_e aluOp;

  // main decode: opcode only
  always_comb begin
    ctl          = '0;
    ctl.aluCtl   = ALU_ADD;
    aluOp        = AOP_ADD;
    unique case (opcode)
      OP_REG: begin
        ctl.regDst   = 1'b1;
        ctl.regWrite = 1'b1;
        aluOp        = AOP_FUNCT;
      end
      OP_LOAD: begin
        ctl.aluSrc   = 1'b1;
        ctl.memToReg = 1'b1;
        ctl.regWrite = 1'b1;
        ctl.memRead  = 1'b1;
      end
      OP_STORE: begin
        ctl.aluSrc   = 1'b1;
        ctl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch   = 1'b1;
        aluOp        = AOP_SUB;
      end
      OP_JUMP: begin
        ctl.jump     = 1'b1;
      end
      default: ;
    endcase

    // second level: ALU operation from ALUOp and funct
    unique case (aluOp)
      AOP_SUB:   ctl.aluCtl = ALU_SUB;
      AOP_FUNCT: begin
        unique case (funct)
          FN_SUB:  ctl.aluCtl = ALU_SUB;
          FN_AND:  ctl.aluCtl = ALU_AND;
          FN_OR:   ctl.aluCtl = ALU_OR;
          FN_SLT:  ctl.aluCtl = ALU_SLT;
          default: ctl.aluCtl = ALU_ADD;
        endcase
      end
      default:   ctl.aluCtl = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int AW = 5,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);

  localparam int N = 1 << AW;

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  aluCtl_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  logic [W-1:0] diff;

  assign diff = a - b;

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctl,
  output logic [XLEN-1:0] instrWord,
  output logic [XLEN-1:0] pcOut,
  output logic            dmemWe,
  output logic [XLEN-1:0] dmemAddr,
  output logic [XLEN-1:0] dmemWdata
);

  localparam int IA_W = $clog2(IMEM_WORDS);
  localparam int DA_W = $clog2(DMEM_WORDS);

  logic [XLEN-1:0]   imem [IMEM_WORDS];
  logic [XLEN-1:0]   dmem [DMEM_WORDS];

  logic [XLEN-1:0]   pc, pcPlus4, brTarget, jmpTarget, pcNext;
  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, wrIdx;
  logic [XLEN-1:0]   rsVal, rtVal, immExt, aluB, aluY, memRdata, wbData;
  logic [DA_W-1:0]   dIdx;
  logic              aluZero, takeBranch;

  // contents are loaded from outside before reset is released
  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
  end

  // fetch
  assign instrWord = imem[pc[IA_W+1:2]];

  // operand fields
  assign rsIdx  = instrWord[25:21];
  assign rtIdx  = instrWord[20:16];
  assign rdIdx  = instrWord[15:11];
  assign immExt = {{(XLEN-IMM_W){instrWord[IMM_W-1]}}, instrWord[IMM_W-1:0]};
  assign wrIdx  = ctl.regDst ? rdIdx : rtIdx;

  sc_regfile #(.AW(REG_AW), .W(XLEN)) regs (
    .clk (clk),
    .we  (ctl.regWrite & ~rst),
    .ra1 (rsIdx),
    .ra2 (rtIdx),
    .wa  (wrIdx),
    .wd  (wbData),
    .rd1 (rsVal),
    .rd2 (rtVal)
  );

  assign aluB = ctl.aluSrc ? immExt : rtVal;

  sc_alu #(.W(XLEN)) alu (
    .a    (rsVal),
    .b    (aluB),
    .op   (ctl.aluCtl),
    .y    (aluY),
    .zero (aluZero)
  );

  // data memory, word addressed
  assign dIdx     = aluY[DA_W+1:2];
  assign memRdata = ctl.memRead ? dmem[dIdx] : '0;
  assign wbData   = ctl.memToReg ? memRdata : aluY;

  always_ff @(posedge clk) begin
    if (ctl.memWrite && !rst) dmem[dIdx] <= rtVal;
  end

  // next PC selection
  assign pcPlus4    = pc + XLEN'(4);
  assign brTarget   = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign jmpTarget  = {pcPlus4[XLEN-1:XLEN-4], instrWord[25:0], 2'b00};
  assign takeBranch = ctl.branch & aluZero;

  always_comb begin
    if (ctl.jump)        pcNext = jmpTarget;
    else if (takeBranch) pcNext = brTarget;
    else                 pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  assign pcOut     = pc;
  assign dmemWe    = ctl.memWrite & ~rst;
  assign dmemAddr  = aluY;
  assign dmemWdata = rtVal;

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pcOut,
  output logic        dmemWe,
  output logic [31:0] dmemAddr,
  output logic [31:0] dmemWdata
);

  ctrl_t           ctl;
  logic [XLEN-1:0] instrWord;

  sc_control ctrl (
    .opcode (instrWord[31:26]),
    .funct  (instrWord[5:0]),
    .ctl    (ctl)
  );

  sc_datapath #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .instrWord (instrWord),
    .pcOut     (pcOut),
    .dmemWe    (dmemWe),
    .dmemAddr  (dmemAddr),
    .dmemWdata (dmemWdata)
  );

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pcOut,
  input logic        dmemWe,
  input ctrl_t       ctl,
  input logic [31:0] instrWord
);

  logic        seenRst;
  logic [31:0] pcInc, jumpDest;

  always_ff @(posedge clk) begin
    if (rst) seenRst <= 1'b1;
    else if (seenRst !== 1'b1) seenRst <= 1'b0;
  end

  assign pcInc    = pcOut + 32'd4;
  assign jumpDest = {pcInc[31:28], instrWord[25:0], 2'b00};

  // R1
  rst_pc_zero_chk: assert property (@(posedge clk) rst |=> pcOut == 32'd0);

  // R1
  rst_no_store_chk: assert property (@(posedge clk) rst |-> !dmemWe);

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (seenRst && !ctl.branch && !ctl.jump) |=> pcOut == $past(pcOut) + 32'd4);

  // R2
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    seenRst |-> pcOut[1:0] == 2'b00);

  // R8
  jump_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (seenRst && ctl.jump) |=> pcOut == $past(jumpDest));

  // R4
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    (seenRst && dmemWe) |-> instrWord[31:26] == 6'h2B);

endmodule

bind sc_core sc_core_chk chk (
  .clk       (clk),
  .rst       (rst),
  .pcOut     (pcOut),
  .dmemWe    (dmemWe),
  .ctl       (ctl),
  .instrWord (instrWord)
);

// File: tb/sc_core_test.sv
module sc_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pcOut, dmemAddr, dmemWdata;
  logic        dmemWe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] prog  [256];
  logic [31:0] mRegs [32];
  logic [31:0] mMem  [64];
  string       regTag[32];
  logic [31:0] mPc;
  string       pcTag;

  localparam int BODY_LEN = 150;

  sc_core uut (
    .clk       (clk),
    .rst       (rst),
    .pcOut     (pcOut),
    .dmemWe    (dmemWe),
    .dmemAddr  (dmemAddr),
    .dmemWdata (dmemWdata)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] encJ(int wordAddr);
    return {6'h02, 26'(wordAddr)};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%08h expected=%08h at pc=%08h", tag, what, act, exp, mPc);
    end
  endtask

  // compare the ports against the model for the instruction at mPc
  task automatic checkCycle();
    logic [31:0] ins, expAddr;
    logic [15:0] imm;
    ins = prog[mPc[9:2]];
    imm = ins[15:0];
    chk(pcOut === mPc, pcTag, "pc", pcOut, mPc);
    if (ins[31:26] == 6'h2B) begin
      expAddr = mRegs[ins[25:21]] + {{16{imm[15]}}, imm};
      chk(dmemWe === 1'b1, "R4", "store strobe", 32'(dmemWe), 32'd1);
      chk(dmemAddr === expAddr, imm[15] ? "R9" : "R4", "store address", dmemAddr, expAddr);
      chk(dmemWdata === mRegs[ins[20:16]], regTag[ins[20:16]], "store data",
          dmemWdata, mRegs[ins[20:16]]);
    end else begin
      chk(dmemWe === 1'b0, "R4", "no strobe for non-store", 32'(dmemWe), 32'd0);
    end
  endtask

  task automatic stepModel();
    logic [31:0] ins, a, b, res, ext, nxt, pc4;
    int rs, rt, rd;
    ins = prog[mPc[9:2]];
    rs  = int'(ins[25:21]);
    rt  = int'(ins[20:16]);
    rd  = int'(ins[15:11]);
    a   = mRegs[rs];
    b   = mRegs[rt];
    ext = {{16{ins[15]}}, ins[15:0]};
    pc4 = mPc + 32'd4;
    nxt = pc4;
    pcTag = "R2";
    case (ins[31:26])
      6'h00: begin
        case (ins[5:0])
          6'h22:   res = a - b;
          6'h24:   res = a & b;
          6'h25:   res = a | b;
          6'h2A:   res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: res = a + b;
        endcase
        if (rd != 0) begin mRegs[rd] = res; regTag[rd] = "R3"; end
      end
      6'h23: if (rt != 0) begin mRegs[rt] = mMem[5'(0) + (a + ext) >> 2 & 32'h3F]; regTag[rt] = "R5"; end
      6'h2B: mMem[(a + ext) >> 2 & 32'h3F] = b;
      6'h04: begin
        pcTag = "R7";
        if (a == b) begin
          nxt = pc4 + {ext[29:0], 2'b00};
          if (ext[31]) pcTag = "R9";
        end
      end
      6'h02: begin
        pcTag = "R8";
        nxt = {pc4[31:28], ins[25:0], 2'b00};
      end
      default: begin
        pcTag = "R10";
        if (rt != 0) regTag[rt] = "R10";
      end
    endcase
    mRegs[0] = 32'd0;
    mPc = nxt;
  endtask

  task automatic buildProgram();
    int n, endIdx, k, pick;
    for (int i = 0; i < 256; i++) prog[i] = 32'd0;
    // memory image
    for (int i = 0; i < 64; i++) mMem[i] = $urandom;
    mMem[3]  = 32'h7FFF_FFFF;
    mMem[4]  = 32'h8000_0000;
    mMem[6]  = mMem[5];
    mMem[7]  = 32'd0;
    mMem[28] = 32'd128;
    mMem[29] = 32'd3;
    mMem[30] = 32'd1;
    mMem[31] = 32'hFFFF_FFFF;
    n = 0;
    // R1: a store at address 0 must not fire while reset is held
    prog[n++] = encI(6'h2B, 0, 0, 252);
    // load every register from its own word
    for (int r = 1; r < 32; r++) prog[n++] = encI(6'h23, 0, r, 4 * r);
    // R6: a load into register 0 is dropped
    prog[n++] = encI(6'h23, 0, 0, 12);
    prog[n++] = encI(6'h2B, 28, 0, -128);
    // R7/R9: down-counting loop closed by a backward branch
    prog[n++] = encR(29, 30, 29, 6'h22);
    prog[n++] = encI(6'h04, 29, 0, 1);
    prog[n++] = encI(6'h04, 0, 0, -3);
    prog[n++] = encI(6'h2B, 28, 29, -4);
    // R10: unsupported opcode leaves register 5 alone
    prog[n++] = encI(6'h08, 0, 5, 7);
    prog[n++] = encI(6'h2B, 28, 5, 8);
    // R3: signed compare across the sign boundary
    prog[n++] = encR(4, 3, 8, 6'h2A);
    prog[n++] = encR(3, 4, 9, 6'h2A);
    prog[n++] = encI(6'h2B, 28, 8, 12);
    prog[n++] = encI(6'h2B, 28, 9, 16);
    endIdx = n + BODY_LEN;
    for (int i = n; i < endIdx; i++) begin
      pick = int'($urandom_range(0, 99));
      if (pick < 50) begin
        logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
        prog[i] = encR(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                       ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(1, 27)),
                       fns[$urandom_range(0, 4)]);
      end else if (pick < 65) begin
        prog[i] = encI(6'h2B, 28, int'($urandom_range(0, 31)),
                       4 * (int'($urandom_range(0, 63)) - 32));
      end else if (pick < 80) begin
        prog[i] = encI(6'h23, 28, int'($urandom_range(0, 27)),
                       4 * (int'($urandom_range(0, 63)) - 32));
      end else if (pick < 92) begin
        int rsI, rtI;
        rsI = int'($urandom_range(0, 31));
        rtI = ($urandom_range(0, 2) == 0) ? rsI : int'($urandom_range(0, 31));
        k = int'($urandom_range(0, 3));
        if (i + 1 + k > endIdx) k = endIdx - i - 1;
        prog[i] = encI(6'h04, rsI, rtI, k);
      end else begin
        k = i + 1 + int'($urandom_range(0, 3));
        if (k > endIdx) k = endIdx;
        prog[i] = encJ(k);
      end
    end
    // park on a self jump
    prog[endIdx] = encJ(endIdx);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    buildProgram();
    #1;
    for (int i = 0; i < 256; i++) uut.dp.imem[i] = prog[i];
    for (int i = 0; i < 64; i++)  uut.dp.dmem[i] = mMem[i];
    for (int r = 0; r < 32; r++) begin
      mRegs[r]  = 32'd0;
      regTag[r] = "R6";
    end
    mPc   = 32'd0;
    pcTag = "R1";
    repeat (3) @(negedge clk);
    // R1: reset state, store at address 0 held off
    chk(pcOut === 32'd0, "R1", "pc in reset", pcOut, 32'd0);
    chk(dmemWe === 1'b0, "R1", "store strobe in reset", 32'(dmemWe), 32'd0);
    @(negedge clk);
    chk(pcOut === 32'd0, "R1", "pc held in reset", pcOut, 32'd0);
    rst = 1'b0;
    #1;
    for (int cyc = 0; cyc < 400; cyc++) begin
      checkCycle();
      stepModel();
      @(negedge clk);
      #1;
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule